// File: doc/BRIEF.md
# I2C Byte-Level Master Transmitter

This block is a bus master that writes bytes onto a two-wire I2C bus. A host drives it through three small registers: a byte buffer, a command register and a status register. The host places a byte in the buffer, then writes a command word. The command holds a launch bit, which self-clears, and two qualifiers. One asks for a START condition before the byte and the other asks for a STOP condition after it. The block shifts the byte out MSB first and releases SDA for the ninth clock so that the target can acknowledge. It then stores the sampled acknowledge bit and raises a sticky transmit-empty flag. The host clears that flag by writing a 1 to it.

A transfer usually begins with an address byte. That byte carries the 7-bit target address in bits 7:1 and the read/write flag in bit 0, where 0 means write. Data bytes follow. If a byte ends without a STOP request, the block keeps the bus and holds SCL low until the next launch. SCL timing comes from a fixed divider: each SCL period is four phases of `DIV` clock cycles. Both lines are open-drain, so each one is modelled as an output enable that pulls the line low when set.

Host register map. The address is `wr_addr`:
- 0: byte buffer.
- 1: command. Bit 0 is launch, bit 1 is START request, bit 2 is STOP request, bit 3 is arbitration-loss interrupt enable.
- 2: status clear. Bit 0 clears transmit-empty when written as 1.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, busy, transmit-empty, the acknowledge bit, the read/write flag, all command bits and both output enables are 0.
- R2: A launch with START, written while the unit is idle, does the following in order: a START condition (SDA falls while SCL is high), the eight buffer bits MSB first, and a ninth clock with SDA released. Transmit-empty rises 1+40*DIV cycles after the command write.
- R3: The launch bit (command bit 0) reads back 0 one cycle after a command write that starts a transfer.
- R4: A byte that ends without STOP leaves busy at 1 and SCL held low. The read/write flag output reports bit 0 of the byte sent after the last START.
- R5: Writing status bit 0 as 1 clears transmit-empty. Writing 0 to it leaves the flag set.
- R6: A launch without START while the bus is held sends the byte with no START condition. Transmit-empty rises 1+36*DIV cycles after the command write.
- R7: With STOP requested, a STOP condition (SDA rises while SCL is high) follows the ninth clock. Busy drops 4*DIV cycles after transmit-empty rises, and both lines are then released.
- R8: The acknowledge output holds the SDA level sampled during the ninth clock of the last byte: 0 for ACK, 1 for NAK.
- R9: Outside START and STOP, SDA changes only while SCL is low, and each transfer produces exactly the requested START and STOP conditions.
- R10: The arbitration-loss enable (command bit 3) is cleared when a transfer launches. A write that sets it while busy has no effect.
- R11: A launch while idle issues a START condition even if the START request is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 2 | Register select: 0 buffer, 1 command, 2 status clear |
| wr_data | input | 8 | Host write data |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | Pulls SCL low when 1 |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| busy | output | 1 | Unit owns the bus |
| tx_empty | output | 1 | Byte finished; sticky until cleared |
| ack_nak | output | 1 | Sampled acknowledge bit of the last byte |
| rnw | output | 1 | Read/write flag of the last address byte |
| ctrl_q | output | 4 | Command register read-back {alie, stop, start, launch} |

## Verification
The bench counts clock edges from the edge that captures the command write. The launch bit must be clear one edge later. Transmit-empty must still be low at edge 40*DIV and high at edge 40*DIV+1 when a START is sent; without a START the same pair of samples falls at 36*DIV and 36*DIV+1. Busy is sampled 4*DIV-1 and 4*DIV edges after transmit-empty rises, so each timing check brackets the exact edge on both sides. Bus-level results come from a slave model in the bench, which decodes START, STOP and the data bits and drives the acknowledge. These results are read a few cycles after the byte ends, once the model has settled.

// File: rtl/i2c_byte_master.sv
`timescale 1ns/1ps
module i2c_byte_master #(
  parameter int DIV = 125
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       busy,
  output logic       tx_empty,
  output logic       ack_nak,
  output logic       rnw,
  output logic [3:0] ctrl_q
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_BITS, S_STOP, S_HOLD} st_t;
  st_t st;

  logic [CW-1:0] cnt;
  logic [1:0]    ph;
  logic [3:0]    bcnt;
  logic [7:0]    dreg, sh;
  logic go_q, sta_q, sto_q, alie_q, stop_pend;
  logic scl_q, sda_q, txe_q, nak_q, rnw_q;

  wire dat_wr    = wr_en && wr_addr == 2'd0;
  wire ctl_wr    = wr_en && wr_addr == 2'd1;
  wire sts_wr    = wr_en && wr_addr == 2'd2;
  wire active    = st == S_START || st == S_BITS || st == S_STOP;
  wire launch    = go_q && !ctl_wr && (st == S_IDLE || st == S_HOLD);
  wire add_start = sta_q || st == S_IDLE;
  wire tick      = active && cnt == CW'(DIV - 1);
  wire byte_done = tick && st == S_BITS && ph == 2'd3 && bcnt == 4'd8;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q <= 1'b0; sta_q <= 1'b0; sto_q <= 1'b0; alie_q <= 1'b0;
    end else if (ctl_wr) begin
      go_q   <= wr_data[0];
      sta_q  <= wr_data[1];
      sto_q  <= wr_data[2];
      alie_q <= (st == S_IDLE) ? wr_data[3] : alie_q;
    end else if (launch) begin
      go_q   <= 1'b0;
      alie_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dreg <= '0;
    else if (dat_wr) dreg <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) txe_q <= 1'b0;
    else if (byte_done) txe_q <= 1'b1;
    else if (sts_wr && wr_data[0]) txe_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; ph <= '0; bcnt <= '0; sh <= '0;
      scl_q <= 1'b0; sda_q <= 1'b0; nak_q <= 1'b0; rnw_q <= 1'b0;
      stop_pend <= 1'b0;
    end else if (launch) begin
      cnt <= '0; ph <= '0; bcnt <= '0;
      sh <= dreg;
      stop_pend <= sto_q;
      if (add_start) begin
        st    <= S_START;
        rnw_q <= dreg[0];
        sda_q <= 1'b0;
      end else begin
        st <= S_BITS;
      end
    end else if (active) begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (tick) begin
        ph <= ph + 2'd1;
        case (st)
          S_START:
            case (ph)
              2'd0: scl_q <= 1'b0;
              2'd1: sda_q <= 1'b1;
              2'd2: scl_q <= 1'b1;
              default: begin st <= S_BITS; bcnt <= '0; end
            endcase
          S_BITS:
            case (ph)
              2'd0: sda_q <= (bcnt < 4'd8) ? ~sh[7] : 1'b0;
              2'd1: scl_q <= 1'b0;
              2'd2: if (bcnt == 4'd8) nak_q <= sda_in;
              default: begin
                scl_q <= 1'b1;
                if (bcnt == 4'd8) st <= stop_pend ? S_STOP : S_HOLD;
                else begin
                  bcnt <= bcnt + 4'd1;
                  sh   <= {sh[6:0], 1'b0};
                end
              end
            endcase
          S_STOP:
            case (ph)
              2'd0: sda_q <= 1'b1;
              2'd1: scl_q <= 1'b0;
              2'd2: sda_q <= 1'b0;
              default: st <= S_IDLE;
            endcase
          default: ;
        endcase
      end
    end
  end

  assign scl_oe   = scl_q;
  assign sda_oe   = sda_q;
  assign busy     = st != S_IDLE;
  assign tx_empty = txe_q;
  assign ack_nak  = nak_q;
  assign rnw      = rnw_q;
  assign ctrl_q   = {alie_q, sto_q, sta_q, go_q};

  assert_sda_stable_scl_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BITS && $past(st) == S_BITS && (!scl_q || !$past(scl_q))) |-> $stable(sda_q));

  assert_ack_slot_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BITS && bcnt == 4'd8 && ph != 2'd0) |-> !sda_q);

  assert_alie_clear_when_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !alie_q);

  assert_launch_self_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && go_q && !ctl_wr) |=> (!go_q && st == S_START));

  assert_txe_rise_at_byte_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txe_q) |-> (st == S_HOLD || st == S_STOP) && scl_q);

  assert_stop_releases_lines_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_STOP && st == S_IDLE) |-> (!scl_q && !sda_q));

  assert_w1c_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && wr_data[0] && !byte_done) |=> !txe_q);
endmodule

// File: tb/i2c_byte_master_tb.sv
`timescale 1ns/1ps
module i2c_byte_master_tb;
  localparam int DIV = 4;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic scl_oe, sda_oe, busy, tx_empty, ack_nak, rnw;
  logic [3:0] ctrl_q;
  logic slv_drv = 1'b0, ack_en = 1'b1;
  wire scl_line = ~scl_oe;
  wire sda_line = ~sda_oe & ~slv_drv;

  always #2.5 clk = ~clk;

  i2c_byte_master #(.DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy),
    .tx_empty(tx_empty), .ack_nak(ack_nak), .rnw(rnw), .ctrl_q(ctrl_q));

  int checks = 0, errors = 0;
  int n_start = 0, n_stop = 0, nbits = 0;
  logic [7:0] cap = '0, last_byte = '0;
  logic pscl = 1'b1, psda = 1'b1;

  always @(negedge clk) begin
    if (pscl && scl_line && psda && !sda_line) begin n_start++; nbits = 0; end
    else if (pscl && scl_line && !psda && sda_line) n_stop++;
    if (!pscl && scl_line) begin
      if (nbits < 8) cap = {cap[6:0], sda_line};
      nbits++;
    end
    if (pscl && !scl_line) begin
      if (nbits == 8) slv_drv = ack_en;
      else if (nbits == 9) begin slv_drv = 1'b0; last_byte = cap; nbits = 0; end
    end
    pscl = scl_line;
    psda = sda_line;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_n(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1", "busy", busy, 0);
    chk("R1", "tx_empty", tx_empty, 0);
    chk("R1", "ack_nak", ack_nak, 0);
    chk("R1", "rnw", rnw, 0);
    chk("R1", "ctrl", ctrl_q, 0);
    chk("R1", "scl_oe", scl_oe, 0);
    chk("R1", "sda_oe", sda_oe, 0);
  endtask

  task automatic t_addr_byte;
    wr(2'd0, 8'hA4);
    wr(2'd1, 8'h03);
    wait_n(1);
    chk("R3", "launch bit", ctrl_q[0], 0);
    chk("R2", "busy after launch", busy, 1);
    wait_n(40*DIV - 1);
    chk("R2", "tx_empty early", tx_empty, 0);
    wait_n(1);
    chk("R2", "tx_empty due", tx_empty, 1);
    wait_n(2);
    chk("R2", "byte on bus", last_byte, 8'hA4);
    chk("R9", "start count", n_start, 1);
    chk("R9", "stop count", n_stop, 0);
    chk("R8", "ack", ack_nak, 0);
    chk("R4", "rnw", rnw, 0);
    chk("R4", "busy held", busy, 1);
    chk("R4", "scl held low", scl_oe, 1);
  endtask

  task automatic t_w1c;
    wr(2'd2, 8'h00);
    chk("R5", "write 0 keeps flag", tx_empty, 1);
    wr(2'd2, 8'h01);
    chk("R5", "write 1 clears flag", tx_empty, 0);
  endtask

  task automatic t_data_stop;
    wr(2'd0, 8'h3C);
    wr(2'd1, 8'h05);
    wait_n(1);
    chk("R3", "launch bit", ctrl_q[0], 0);
    wait_n(36*DIV - 1);
    chk("R6", "tx_empty early", tx_empty, 0);
    wait_n(1);
    chk("R6", "tx_empty due", tx_empty, 1);
    wait_n(4*DIV - 1);
    chk("R7", "busy before stop end", busy, 1);
    wait_n(1);
    chk("R7", "busy after stop", busy, 0);
    chk("R7", "scl released", scl_oe, 0);
    chk("R7", "sda released", sda_oe, 0);
    wait_n(2);
    chk("R6", "byte on bus", last_byte, 8'h3C);
    chk("R6", "no new start", n_start, 1);
    chk("R7", "stop count", n_stop, 1);
  endtask

  task automatic t_nak_forced_start;
    wr(2'd2, 8'h01);
    ack_en = 1'b0;
    wr(2'd0, 8'h91);
    wr(2'd1, 8'h05);
    wait_n(40*DIV);
    chk("R11", "tx_empty early", tx_empty, 0);
    wait_n(1);
    chk("R11", "tx_empty due", tx_empty, 1);
    wait_n(2);
    chk("R11", "forced start", n_start, 2);
    chk("R8", "nak", ack_nak, 1);
    chk("R4", "rnw read flag", rnw, 1);
    chk("R2", "byte on bus", last_byte, 8'h91);
    wait_n(4*DIV);
    chk("R7", "idle after stop", busy, 0);
    chk("R9", "stop count", n_stop, 2);
    ack_en = 1'b1;
  endtask

  task automatic t_alie;
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h20);
    wr(2'd1, 8'h0B);
    wait_n(1);
    chk("R10", "alie cleared at launch", ctrl_q[3], 0);
    chk("R10", "busy", busy, 1);
    wr(2'd1, 8'h08);
    chk("R10", "alie write ignored", ctrl_q[3], 0);
    wait_n(40*DIV - 2);
    chk("R2", "tx_empty due", tx_empty, 1);
    wait_n(2);
    chk("R8", "ack after nak", ack_nak, 0);
    chk("R2", "byte on bus", last_byte, 8'h20);
    chk("R9", "start count", n_start, 3);
    wr(2'd1, 8'h08);
    chk("R10", "alie ignored in hold", ctrl_q[3], 0);
  endtask

  initial begin
    wait_n(3);
    t_reset();
    rst_n = 1'b1;
    wait_n(2);
    t_addr_byte();
    t_w1c();
    t_data_stop();
    t_nak_forced_start();
    t_alie();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule